// File: doc/BRIEF.md
# Synchronized Multi-Converter Update Sequencer

This block is the host-side controller for a set of double-buffered digital-to-analog converters that share one parallel data bus. Each converter has a first-stage holding latch with its own active-low enable, and a second-stage output latch whose active-low enable is wired in common to all converters. A request stream carries one of four operations: a channel write, a commit, a clear, or a no-op. A write loads one converter's first stage. A commit pulses only the shared second-stage enable, so every converter moves its held word to its output on the same strobe edge.

Every bus timing minimum is a parameter in nanoseconds. The block turns each one into a whole number of system clock cycles, rounding up. These minimums are: data and enable setup to the rising end of the strobe, hold after that edge, strobe low width, and clear low width. A static mode input selects single-buffered operation. In that mode a write opens both stages at once and uses the longer strobe width needed for data to pass through both latches. Requests use a ready/valid handshake and are taken only while the sequencer is idle.

Top module: `dacseq_update_ctrl`

## Requirements
- R1: While reset is held, and on leaving it, `dac_wr_n`, `dac_clr_n`, `dac_out_en_n` and every bit of `dac_in_en_n` are 1, `dac_data` is 0 and `req_ready` is 1.
- R2: An accepted write (`req_kind` = 2'b00) drives `req_word` onto `dac_data` and pulls low only bit `req_chan` of `dac_in_en_n`. In double-buffered mode `dac_out_en_n` stays 1 throughout. At most one `dac_in_en_n` bit is ever low.
- R3: Bus data and enables appear one cycle before `dac_wr_n` falls and hold still while it is low. `dac_wr_n` stays low for exactly 7 cycles in double-buffered mode (50 ns at 8 ns). Data is therefore valid for at least 7 cycles before the strobe rises.
- R4: After `dac_wr_n` rises, data and enables stay unchanged for exactly 2 cycles (10 ns rounded up). Then all enables return to 1.
- R5: A commit (`req_kind` = 2'b01) strobes `dac_wr_n` with `dac_out_en_n` low and all `dac_in_en_n` bits 1. The outputs of all converters change on the same cycle.
- R6: With `sb_mode` = 1, a write pulls the addressed `dac_in_en_n` bit and `dac_out_en_n` low together. `dac_wr_n` then stays low for 10 cycles (80 ns rounded up), and only the addressed converter's output changes.
- R7: A clear (`req_kind` = 2'b10) holds `dac_clr_n` low for exactly 25 cycles (200 ns at 8 ns). During that time the strobe and all enables stay 1. It returns every converter to code 0.
- R8: `req_ready` is 1 only while idle. A request presented while busy is not taken and causes no later strobe.
- R9: A no-op request (`req_kind` = 2'b11) is consumed with no strobe, enable or clear activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sb_mode | input | 1 | 1 selects single-buffered writes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request taken this cycle |
| req_kind | input | 2 | 00 write, 01 commit, 10 clear, 11 no-op |
| req_chan | input | CH_W | Target channel of a write |
| req_word | input | DATA_W | Word for a write |
| dac_data | output | DATA_W | Shared converter data bus |
| dac_wr_n | output | 1 | Write strobe, active low |
| dac_in_en_n | output | NUM_CH | Per-channel first-stage enables, active low |
| dac_out_en_n | output | 1 | Common second-stage enable, active low |
| dac_clr_n | output | 1 | Clear pulse, active low |

## Verification
Two functions share one cycle here. First, the commit moves the held word to the output of every converter on a single rising strobe edge. Second, in single-buffered mode a write fills the first and second stage on that same edge. The bench loads four channels with distinct words and then commits. Behavioural latch models record the cycle on which each output changed, and all four stamps must be equal. A single-buffered write must also update its own output at once while leaving the others unchanged.

// File: rtl/dacseq_pkg.sv
// Shared types and helpers for the converter update sequencer.
// Assumes all timing values are positive integers in nanoseconds.
package dacseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_CLEAR
    } seq_state_t;

    typedef enum logic [1:0] {
        OP_WRITE  = 2'b00,
        OP_COMMIT = 2'b01,
        OP_CLEAR  = 2'b10,
        OP_NONE   = 2'b11
    } seq_op_t;

    // Whole clock cycles that cover a minimum time, rounded up.
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacseq_cycle_timer.sv
// Loadable down-counter that times each phase of the sequence.
// Loading N-1 on entry makes the phase last N cycles; expired is high
// in the last cycle. Assumes load values fit in CNT_W bits.
module dacseq_cycle_timer #(
    parameter int unsigned CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, or restart on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/dacseq_lane_decode.sv
// Turns a channel number into active-low per-channel enables.
// At most one lane is low; channel numbers at or above NUM_CH select none.
module dacseq_lane_decode #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CH_W   = 2
) (
    input  logic [CH_W-1:0]   chan,
    input  logic              enable,
    output logic [NUM_CH-1:0] lane_n
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_lane
        assign lane_n[i] = !(enable && (chan == CH_W'(i)));
    end

endmodule

// File: rtl/dacseq_update_ctrl.sv
// Sequencer for a bank of double-buffered converters on one shared bus.
// Writes load one first-stage latch, a commit pulses the common second
// stage, a clear holds the clear line low for its minimum width.
// Assumes converters latch on the rising end of dac_wr_n and that
// sb_mode is changed only while req_ready is high.
module dacseq_update_ctrl
    import dacseq_pkg::*;
#(
    parameter int unsigned NUM_CH      = 4,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned CLK_NS      = 8,
    parameter int unsigned SETUP_NS    = 50,
    parameter int unsigned HOLD_NS     = 10,
    parameter int unsigned PULSE_NS    = 50,
    parameter int unsigned PULSE_SB_NS = 80,
    parameter int unsigned CLEAR_NS    = 200,
    localparam int unsigned CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_mode,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [CH_W-1:0]   req_chan,
    input  logic [DATA_W-1:0] req_word,
    output logic [DATA_W-1:0] dac_data,
    output logic              dac_wr_n,
    output logic [NUM_CH-1:0] dac_in_en_n,
    output logic              dac_out_en_n,
    output logic              dac_clr_n
);

    localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_NS);
    localparam int unsigned HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_NS);
    localparam int unsigned PW_CYC    = ns_to_cyc(PULSE_NS, CLK_NS);
    localparam int unsigned PW_SB_CYC = ns_to_cyc(PULSE_SB_NS, CLK_NS);
    localparam int unsigned CLR_CYC   = ns_to_cyc(CLEAR_NS, CLK_NS);
    // Lead before the strobe falls: whatever setup the pulse does not cover, at least 1.
    localparam int unsigned LEAD_DB   = (SETUP_CYC > PW_CYC) ? SETUP_CYC - PW_CYC : 1;
    localparam int unsigned LEAD_SB   = (SETUP_CYC > PW_SB_CYC) ? SETUP_CYC - PW_SB_CYC : 1;
    localparam int unsigned MAX_CYC   = max2(max2(max2(LEAD_DB, LEAD_SB), max2(PW_CYC, PW_SB_CYC)),
                                             max2(HOLD_CYC, CLR_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [NUM_CH-1:0] LANES_OFF = '1;

    if (SETUP_CYC < 1 || HOLD_CYC < 1 || PW_CYC < 1 || PW_SB_CYC < 1 || CLR_CYC < 1) begin : g_bad_timing
        $error("dacseq_update_ctrl: every timing minimum must map to at least one cycle");
    end

    seq_state_t        state_q;
    seq_op_t           op;
    logic              accept;
    logic              op_sb_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic [NUM_CH-1:0] lane_sel_n;

    assign op        = seq_op_t'(req_kind);
    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;

    dacseq_lane_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_lane_decode (
        .chan   (req_chan),
        .enable (op == OP_WRITE),
        .lane_n (lane_sel_n)
    );

    dacseq_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_phase_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // Choose the length of the phase that starts on this edge.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    tmr_load = 1'b1;
                    unique case (op)
                        OP_WRITE:  tmr_val = sb_mode ? CNT_W'(LEAD_SB - 1) : CNT_W'(LEAD_DB - 1);
                        OP_COMMIT: tmr_val = CNT_W'(LEAD_DB - 1);
                        OP_CLEAR:  tmr_val = CNT_W'(CLR_CYC - 1);
                        default:   tmr_val = '0;
                    endcase
                end
            end
            ST_SETUP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = op_sb_q ? CNT_W'(PW_SB_CYC - 1) : CNT_W'(PW_CYC - 1);
                end
            end
            ST_STROBE: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_CYC - 1);
                end
            end
            default: ;
        endcase
    end

    // Step the sequence and drive the registered bus outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            op_sb_q      <= 1'b0;
            dac_data     <= '0;
            dac_wr_n     <= 1'b1;
            dac_in_en_n  <= LANES_OFF;
            dac_out_en_n <= 1'b1;
            dac_clr_n    <= 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        unique case (op)
                            OP_WRITE: begin
                                state_q      <= ST_SETUP;
                                dac_data     <= req_word;
                                dac_in_en_n  <= lane_sel_n;
                                dac_out_en_n <= !sb_mode;
                                op_sb_q      <= sb_mode;
                            end
                            OP_COMMIT: begin
                                state_q      <= ST_SETUP;
                                dac_out_en_n <= 1'b0;
                                op_sb_q      <= 1'b0;
                            end
                            OP_CLEAR: begin
                                state_q   <= ST_CLEAR;
                                dac_clr_n <= 1'b0;
                            end
                            default: ;
                        endcase
                    end
                end
                ST_SETUP: begin
                    if (tmr_done) begin
                        state_q  <= ST_STROBE;
                        dac_wr_n <= 1'b0;
                    end
                end
                ST_STROBE: begin
                    if (tmr_done) begin
                        state_q  <= ST_HOLD;
                        dac_wr_n <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (tmr_done) begin
                        state_q      <= ST_IDLE;
                        dac_in_en_n  <= LANES_OFF;
                        dac_out_en_n <= 1'b1;
                        op_sb_q      <= 1'b0;
                    end
                end
                ST_CLEAR: begin
                    if (tmr_done) begin
                        state_q   <= ST_IDLE;
                        dac_clr_n <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: never more than one first-stage enable low.
    assert_lane_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~dac_in_en_n));

    // R2: in double-buffered loads the common output enable stays off.
    assert_no_out_during_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((dac_in_en_n != LANES_OFF) && !op_sb_q) |-> dac_out_en_n);

    // R3: bus and enables frozen while the strobe is held low.
    assert_strobe_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_wr_n && !$past(dac_wr_n)) |->
            ($stable(dac_data) && $stable(dac_in_en_n) && $stable(dac_out_en_n)));

    // R4: nothing moves on the strobe's rising edge.
    assert_hold_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_wr_n) |-> ($stable(dac_data) && $stable(dac_in_en_n) && $stable(dac_out_en_n)));

    // R5: a commit opens no first-stage latch.
    assert_commit_only_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_out_en_n && !op_sb_q) |-> (dac_in_en_n == LANES_OFF));

    // R7: the bus is quiet while clear is low.
    assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clr_n |-> (dac_wr_n && dac_out_en_n && (dac_in_en_n == LANES_OFF)));

    // R8: ready means no converter activity in flight.
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (dac_wr_n && dac_clr_n && dac_out_en_n && (dac_in_en_n == LANES_OFF)));

endmodule

// File: tb/dacseq_update_ctrl_tb.sv
// Directed bench with behavioural two-stage converter models.
module dacseq_update_ctrl_tb;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int NUM_CH = 4;
    localparam int DW     = 16;
    localparam int CLK_NS = 8;
    localparam int SETUP_C = (50 + CLK_NS - 1) / CLK_NS;   // 7
    localparam int HOLD_C  = (10 + CLK_NS - 1) / CLK_NS;   // 2
    localparam int PW_C    = (50 + CLK_NS - 1) / CLK_NS;   // 7
    localparam int PWSB_C  = (80 + CLK_NS - 1) / CLK_NS;   // 10
    localparam int CLR_C   = (200 + CLK_NS - 1) / CLK_NS;  // 25
    localparam logic [NUM_CH-1:0] OFF = '1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sb_mode = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = 2'b00;
    logic [1:0] req_chan = '0;
    logic [DW-1:0] req_word = '0;
    logic [DW-1:0] dac_data;
    logic dac_wr_n;
    logic [NUM_CH-1:0] dac_in_en_n;
    logic dac_out_en_n;
    logic dac_clr_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [DW-1:0] m_in  [NUM_CH];
    logic [DW-1:0] m_out [NUM_CH];
    int m_chg [NUM_CH];

    always #4 clk = ~clk;   // 125 MHz

    dacseq_update_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sb_mode(sb_mode),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_chan(req_chan), .req_word(req_word),
        .dac_data(dac_data), .dac_wr_n(dac_wr_n), .dac_in_en_n(dac_in_en_n),
        .dac_out_en_n(dac_out_en_n), .dac_clr_n(dac_clr_n)
    );

    always @(posedge clk) cyc++;

    // Converter latch models: both stages capture on the strobe's rising end.
    always @(posedge dac_wr_n) begin
        if (rst_n === 1'b1) begin
            for (int i = 0; i < NUM_CH; i++)
                if (dac_in_en_n[i] === 1'b0) m_in[i] = dac_data;
            if (dac_out_en_n === 1'b0)
                for (int i = 0; i < NUM_CH; i++)
                    if (m_out[i] !== m_in[i]) begin
                        m_out[i] = m_in[i];
                        m_chg[i] = cyc;
                    end
        end
    end

    always @(negedge dac_clr_n) begin
        if (rst_n === 1'b1)
            for (int i = 0; i < NUM_CH; i++) begin
                m_in[i]  = '0;
                m_out[i] = '0;
            end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write or commit; checks lead, strobe width, setup, hold and stability.
    task automatic run_op(input logic [1:0] kind, input int ch, input logic [DW-1:0] word,
                          input bit sb, input int exp_low, input logic [NUM_CH-1:0] exp_in,
                          input bit exp_out, input string tag);
        int lead, low, hold;
        bit moved;
        logic [DW-1:0] d0;
        logic [NUM_CH-1:0] e0;
        logic o0;
        sb_mode = sb;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_chan = ch[1:0]; req_word = word;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, {tag, " R8 busy after accept"}, req_ready, 0);
        chk(dac_in_en_n == exp_in, {tag, " R2 input enables"}, dac_in_en_n, exp_in);
        chk(dac_out_en_n == exp_out, {tag, " R2 output enable"}, dac_out_en_n, exp_out);
        if (kind == 2'b00) chk(dac_data == word, {tag, " R2 bus word"}, dac_data, word);
        d0 = dac_data; e0 = dac_in_en_n; o0 = dac_out_en_n;
        moved = 1'b0;
        lead = 0;
        while (dac_wr_n && lead < 40) begin lead++; @(negedge clk); end
        low = 0;
        while (!dac_wr_n && low < 40) begin
            if (dac_data != d0 || dac_in_en_n != e0 || dac_out_en_n != o0) moved = 1'b1;
            low++; @(negedge clk);
        end
        chk(lead == 1, {tag, " R3 lead before strobe"}, lead, 1);
        chk(low == exp_low, {tag, " R3/R6 strobe width"}, low, exp_low);
        chk(lead + low >= SETUP_C, {tag, " R3 setup to rising end"}, lead + low, SETUP_C);
        hold = 0;
        while ((dac_in_en_n != OFF || dac_out_en_n == 1'b0) && hold < 40) begin
            if (dac_data != d0 || dac_in_en_n != e0 || dac_out_en_n != o0) moved = 1'b1;
            hold++; @(negedge clk);
        end
        chk(hold == HOLD_C, {tag, " R4 hold after strobe"}, hold, HOLD_C);
        chk(!moved, {tag, " R4 bus stable through strobe and hold"}, moved, 0);
        chk(req_ready == 1'b1, {tag, " R8 ready after sequence"}, req_ready, 1);
    endtask

    task automatic t_reset;
        @(negedge clk); @(negedge clk);
        chk(dac_wr_n && dac_clr_n && dac_out_en_n && dac_in_en_n == OFF, "R1 controls idle in reset",
            {dac_wr_n, dac_clr_n, dac_out_en_n, dac_in_en_n}, 7'h7f);
        chk(dac_data == '0, "R1 bus zero", dac_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    endtask

    task automatic t_load_and_commit;
        logic [DW-1:0] w [NUM_CH];
        w[0] = 16'h8000; w[1] = 16'h1234; w[2] = 16'h7fff; w[3] = 16'hffff;
        for (int c = 0; c < NUM_CH; c++)
            run_op(2'b00, c, w[c], 1'b0, PW_C, OFF & ~(NUM_CH'(1) << c), 1'b1, "write");
        for (int c = 0; c < NUM_CH; c++)
            chk(m_out[c] == '0, "R2 output untouched before commit", m_out[c], 0);
        run_op(2'b01, 0, 16'h0, 1'b0, PW_C, OFF, 1'b0, "commit");
        for (int c = 0; c < NUM_CH; c++) begin
            chk(m_out[c] == w[c], "R5 output after commit", m_out[c], w[c]);
            chk(m_chg[c] == m_chg[0], "R5 outputs change on one cycle", m_chg[c], m_chg[0]);
        end
    endtask

    task automatic t_single_buffered;
        logic [DW-1:0] before1;
        before1 = m_out[1];
        run_op(2'b00, 2, 16'h4000, 1'b1, PWSB_C, 4'b1011, 1'b0, "sb write");
        chk(m_out[2] == 16'h4000, "R6 addressed output updated", m_out[2], 16'h4000);
        chk(m_out[1] == before1, "R6 other output unchanged", m_out[1], before1);
        sb_mode = 1'b0;
    endtask

    task automatic t_clear;
        int n;
        bit noisy;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R8 busy during clear", req_ready, 0);
        n = 0; noisy = 1'b0;
        while (!dac_clr_n && n < 100) begin
            if (!dac_wr_n || !dac_out_en_n || dac_in_en_n != OFF) noisy = 1'b1;
            n++; @(negedge clk);
        end
        chk(n == CLR_C, "R7 clear width", n, CLR_C);
        chk(!noisy, "R7 strobe and enables idle in clear", noisy, 0);
        for (int c = 0; c < NUM_CH; c++)
            chk(m_out[c] == '0, "R7 output cleared to code 0", m_out[c], 0);
    endtask

    task automatic t_busy_ignored;
        int quiet;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b00; req_chan = 2'd1; req_word = 16'h0aaa;
        @(negedge clk);
        req_chan = 2'd3; req_word = 16'h0bbb;   // stays valid 5 cycles while busy
        repeat (5) @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        quiet = 0;
        repeat (12) begin
            if (dac_wr_n && dac_in_en_n == OFF) quiet++;
            @(negedge clk);
        end
        chk(quiet == 12, "R8 busy request caused no strobe", quiet, 12);
        run_op(2'b01, 0, 16'h0, 1'b0, PW_C, OFF, 1'b0, "commit2");
        chk(m_out[1] == 16'h0aaa, "R8 accepted write committed", m_out[1], 16'h0aaa);
        chk(m_out[3] == 16'h0000, "R8 busy word never loaded", m_out[3], 0);
    endtask

    task automatic t_noop;
        int quiet;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'b11;
        @(negedge clk);
        req_valid = 1'b0;
        quiet = 0;
        repeat (12) begin
            if (req_ready && dac_wr_n && dac_clr_n && dac_out_en_n && dac_in_en_n == OFF) quiet++;
            @(negedge clk);
        end
        chk(quiet == 12, "R9 no-op leaves bus idle", quiet, 12);
    endtask

    initial begin
        for (int c = 0; c < NUM_CH; c++) begin
            m_in[c] = '0; m_out[c] = '0; m_chg[c] = 0;
        end
        t_reset();
        t_load_and_commit();
        t_single_buffered();
        t_clear();
        t_busy_ignored();
        t_noop();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired (all requirements) actual=%0d expected=<50000", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule